// File: doc/BRIEF.md
# Reloading Prescaler Tick Counter

This block divides a pulse stream down to a slow, readable count. A down-counting prescaler is moved one step by each single-cycle tick enable. The tick enable comes from the prescale clock domain: nominally 20 MHz, already synchronised, one cycle wide. When a tick arrives while the prescaler already reads zero, the prescaler reloads from a programmable reload register. On that same tick a 32-bit up-counter advances by one. With reload value R the up-counter therefore advances once every R+1 ticks. With R equal to zero the up-counter advances on every tick.

Software sees three registers: the reload value, the live prescaler and the up-counter. Each has a plain write strobe with a data word and a read output that shows the register directly. A starting prescaler above the reload value is legal. The prescaler first runs down to zero from that value and then enters the regular reload cycle. The tick enable is generated outside the block, and the bus decode is also done outside it.

Top module: `presc_tick_counter`

## Requirements
- R1: While rst_n is low, and after its release until the first write or tick, all three read outputs (reload_rd, pre_rd, cnt_rd) are zero.
- R2: On a tick while the prescaler is nonzero and pre_we is low, the prescaler drops by exactly one at that clock edge and the up-counter is unchanged.
- R3: On a tick while the prescaler is zero and pre_we is low, the prescaler loads the reload register value at that clock edge. The up-counter increases by one at the same edge.
- R4: With reload value 5 and a starting prescaler of 7, successive ticks give prescaler values 6,5,4,3,2,1,0,5,4,3,2,1,0,5. The up-counter steps on the 8th and 14th ticks.
- R5: With a reload value of zero, once the prescaler reaches zero it stays at zero and the up-counter increases on every tick.
- R6: In a cycle with no tick and no write strobe, none of the three registers changes.
- R7: A write to the prescaler or to the up-counter takes priority over any tick-driven change of that register in the same cycle. A tick in the same cycle as a prescaler write produces no up-counter increment.
- R8: The up-counter wraps from 0xFFFFFFFF to 0x00000000 on an increment.
- R9: Writing the reload register leaves the current prescaler value untouched, and the new value is used at the next reload. A reload that happens in the same cycle as a reload write uses the value held before that write.
- R10: A write strobe stores its data word at that clock edge, and the matching read output shows the word in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| tick_en | input | 1 | Single-cycle prescale tick enable |
| reload_we | input | 1 | Write strobe for the reload register |
| reload_wdata | input | PRE_W | Reload write data |
| pre_we | input | 1 | Write strobe for the prescaler |
| pre_wdata | input | PRE_W | Prescaler write data |
| cnt_we | input | 1 | Write strobe for the up-counter |
| cnt_wdata | input | CNT_W | Up-counter write data |
| reload_rd | output | PRE_W | Current reload value |
| pre_rd | output | PRE_W | Current prescaler value |
| cnt_rd | output | CNT_W | Current up-counter value |

## Verification
The bench walks the prescaler from above the reload value through two reload cycles. A design that reloaded on reaching zero instead of one tick later would lose a count per period and shift the up-counter steps. A zero reload is run for several ticks, where a design that treated zero as "no reload" would freeze the up-counter. The bench also covers a tick that collides with a prescaler or counter write, a reload write in the very cycle of a reload, and the up-counter wrap at all-ones. Each of these exposes a design that orders the updates wrongly, or that lets the new reload value leak into the live prescaler.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef enum logic [1:0] {
    PRE_HOLD   = 2'd0,
    PRE_LOAD   = 2'd1,
    PRE_DEC    = 2'd2,
    PRE_RELOAD = 2'd3
  } pre_op_e;
endpackage

// File: rtl/ptc_reload_reg.sv
module ptc_reload_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] val_q
);
  logic [W-1:0] val_d;

  always_comb begin
    val_d = val_q;
    if (wr_en) val_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     val_q <= '0;
    else if (wr_en) val_q <= val_d;
  end

  AST_RELOAD_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> val_q == $past(wr_data)); // R10
  AST_RELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(val_q)); // R9
endmodule

// File: rtl/ptc_prescaler.sv
module ptc_prescaler
  import ptc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         load_we,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] pre_q,
  output logic         wrap_o
);
  localparam logic [W-1:0] ONE = W'(1);

  pre_op_e      op;
  logic [W-1:0] pre_d;
  logic         pre_en;
  logic         at_zero;

  assign at_zero = (pre_q == '0);

  always_comb begin
    if (load_we)      op = PRE_LOAD;
    else if (!tick_en) op = PRE_HOLD;
    else if (at_zero) op = PRE_RELOAD;
    else              op = PRE_DEC;
  end

  always_comb begin
    pre_d  = pre_q;
    wrap_o = 1'b0;
    unique case (op)
      PRE_LOAD:   pre_d = load_val;
      PRE_DEC:    pre_d = pre_q - ONE;
      PRE_RELOAD: begin
        pre_d  = reload_val;
        wrap_o = 1'b1;
      end
      default:    pre_d = pre_q;
    endcase
  end

  assign pre_en = (op != PRE_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  AST_PRE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !load_we && pre_q != '0) |=> pre_q == $past(pre_q) - ONE); // R2
  AST_PRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !load_we && pre_q == '0) |=> pre_q == $past(reload_val)); // R3
  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load_we) |=> $stable(pre_q)); // R6
  AST_PRE_WR_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> pre_q == $past(load_val)); // R7
endmodule

// File: rtl/ptc_upcount.sv
module ptc_upcount #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_q
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en)       cnt_d = wr_data;
    else if (inc_en) cnt_d = cnt_q + ONE;
  end

  assign cnt_en = wr_en | inc_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !wr_en) |=> cnt_q == $past(cnt_q) + ONE); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_en && !wr_en) |=> $stable(cnt_q)); // R6
  AST_CNT_WR_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt_q == $past(wr_data)); // R7
endmodule

// File: rtl/presc_tick_counter.sv
module presc_tick_counter #(
  parameter int PRE_W = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             reload_we,
  input  logic [PRE_W-1:0] reload_wdata,
  input  logic             pre_we,
  input  logic [PRE_W-1:0] pre_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [PRE_W-1:0] reload_rd,
  output logic [PRE_W-1:0] pre_rd,
  output logic [CNT_W-1:0] cnt_rd
);
  logic [PRE_W-1:0] reload_q;
  logic             wrap;

  ptc_reload_reg #(.W(PRE_W)) u_reload (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reload_we),
    .wr_data (reload_wdata),
    .val_q   (reload_q)
  );

  ptc_prescaler #(.W(PRE_W)) u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .load_we    (pre_we),
    .load_val   (pre_wdata),
    .reload_val (reload_q),
    .pre_q      (pre_rd),
    .wrap_o     (wrap)
  );

  ptc_upcount #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_en  (wrap),
    .wr_en   (cnt_we),
    .wr_data (cnt_wdata),
    .cnt_q   (cnt_rd)
  );

  assign reload_rd = reload_q;

  AST_WRAP_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (tick_en && !pre_we)); // R3
  AST_ZERO_RELOAD_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !pre_we && pre_rd == '0 && reload_q == '0) |=> pre_rd == '0); // R5
endmodule

// File: tb/presc_tick_counter_bench.sv
module presc_tick_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, reload_we, pre_we, cnt_we;
  logic [31:0] reload_wdata, pre_wdata, cnt_wdata;
  logic [31:0] reload_rd, pre_rd, cnt_rd;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  presc_tick_counter u_presc_tick_counter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .reload_we(reload_we), .reload_wdata(reload_wdata),
    .pre_we(pre_we), .pre_wdata(pre_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .reload_rd(reload_rd), .pre_rd(pre_rd), .cnt_rd(cnt_rd)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    tick_en = 0; reload_we = 0; pre_we = 0; cnt_we = 0;
    reload_wdata = '0; pre_wdata = '0; cnt_wdata = '0;
  endtask

  // Inputs driven at a falling edge, captured by the next rising edge, sampled at the following falling edge.
  task automatic cycle();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic setup(logic [31:0] r, logic [31:0] p, logic [31:0] c);
    reload_we = 1; reload_wdata = r;
    pre_we = 1; pre_wdata = p;
    cnt_we = 1; cnt_wdata = c;
    cycle();
    chk("R10", "reload readback", reload_rd, r);
    chk("R10", "prescaler readback", pre_rd, p);
    chk("R10", "counter readback", cnt_rd, c);
  endtask

  task automatic tick();
    tick_en = 1;
    cycle();
  endtask

  task automatic t_reset();
    chk("R1", "reload after reset", reload_rd, 32'd0);
    chk("R1", "prescaler after reset", pre_rd, 32'd0);
    chk("R1", "counter after reset", cnt_rd, 32'd0);
  endtask

  task automatic t_sequence();
    logic [31:0] exp_p [14] = '{6, 5, 4, 3, 2, 1, 0, 5, 4, 3, 2, 1, 0, 5};
    logic [31:0] exp_c;
    setup(32'd5, 32'd7, 32'd0);
    exp_c = 0;
    for (int i = 0; i < 14; i++) begin
      tick();
      if (i == 7 || i == 13) exp_c++;
      chk("R4", "prescaler sequence", pre_rd, exp_p[i]);
      chk((i == 7 || i == 13) ? "R3" : "R2", "counter in sequence", cnt_rd, exp_c);
    end
  endtask

  task automatic t_hold();
    logic [31:0] p0, c0;
    p0 = pre_rd; c0 = cnt_rd;
    for (int i = 0; i < 4; i++) cycle();
    chk("R6", "prescaler hold", pre_rd, p0);
    chk("R6", "counter hold", cnt_rd, c0);
    chk("R6", "reload hold", reload_rd, 32'd5);
  endtask

  task automatic t_zero_reload();
    setup(32'd0, 32'd2, 32'd10);
    tick(); chk("R2", "down to 1", pre_rd, 32'd1);
    tick(); chk("R2", "down to 0", pre_rd, 32'd0);
    chk("R2", "no step before zero", cnt_rd, 32'd10);
    for (int i = 1; i <= 5; i++) begin
      tick();
      chk("R5", "prescaler stays zero", pre_rd, 32'd0);
      chk("R5", "counter every tick", cnt_rd, 32'd10 + 32'(i));
    end
  endtask

  task automatic t_wrap();
    setup(32'd2, 32'd0, 32'hFFFF_FFFF);
    tick();
    chk("R8", "counter wraps", cnt_rd, 32'd0);
    chk("R3", "reload after zero", pre_rd, 32'd2);
  endtask

  task automatic t_priority();
    setup(32'd3, 32'd0, 32'd50);
    tick_en = 1; pre_we = 1; pre_wdata = 32'd9; cnt_we = 1; cnt_wdata = 32'd100;
    cycle();
    chk("R7", "prescaler write wins", pre_rd, 32'd9);
    chk("R7", "counter write wins", cnt_rd, 32'd100);
    setup(32'd3, 32'd0, 32'd20);
    tick_en = 1; pre_we = 1; pre_wdata = 32'd6;
    cycle();
    chk("R7", "prescaler write no reload", pre_rd, 32'd6);
    chk("R7", "no increment on prescaler write", cnt_rd, 32'd20);
  endtask

  task automatic t_reload_change();
    setup(32'd5, 32'd3, 32'd0);
    reload_we = 1; reload_wdata = 32'd1;
    cycle();
    chk("R9", "prescaler untouched by reload write", pre_rd, 32'd3);
    chk("R10", "new reload readback", reload_rd, 32'd1);
    tick(); tick(); tick();
    chk("R9", "reached zero", pre_rd, 32'd0);
    tick();
    chk("R9", "new reload used", pre_rd, 32'd1);
    setup(32'd4, 32'd0, 32'd0);
    tick_en = 1; reload_we = 1; reload_wdata = 32'd2;
    cycle();
    chk("R9", "same-cycle reload uses old value", pre_rd, 32'd4);
    chk("R9", "reload updated", reload_rd, 32'd2);
    chk("R3", "increment on collided reload", cnt_rd, 32'd1);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    cycle();
    cycle();
    t_reset();
    t_sequence();
    t_hold();
    t_zero_reload();
    t_wrap();
    t_priority();
    t_reload_change();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule